// File: doc/BRIEF.md
# Keyed Self-Test Enable Controller

This block is the control register for a memory built-in self-test engine, together with the three signals that the register drives. Software turns the test engine on by writing a 4-bit key. Only one exact key value counts as "on". Any other pattern, including a corrupted one, leaves the engine off. This guards against a single upset bit enabling the test by accident.

When the key moves into the "on" value, the block holds the test state machine in reset for a fixed number of bus cycles. That number is set by a 2-bit ROM clock divider code. The same code also sets the rate of a one-cycle clock-enable strobe. The strobe paces the test ROM at the system clock divided by 1, 2, 4 or 8.

The register sits behind a simple strobe-based bus port with one address, 32-bit data and a privilege bit. Only privileged writes change the register. An 8-bit spare field is stored and read back but drives nothing.

Top module: `stkey_top`

## Requirements
- R1: After a synchronous reset the key field holds 5h, the divider code holds 0 and the spare field holds 0. A read then returns 0000_0005h, and both `st_enable` and `st_reset` are low.
- R2: `st_enable` is high exactly when key bits [3:0] hold Ah. It follows a write in the cycle after that write's clock edge.
- R3: A write updates key [3:0], divider code [9:8] and spare [23:16] only when `bus_wr`, `bus_priv` and an address equal to `REG_ADDR` all hold together. A write without privilege changes nothing.
- R4: Read data appears on `bus_rdata` in the cycle after the edge that samples `bus_rd`, and is zero in any other cycle. Bits 31:24, 15:10 and 7:4 always read as zero.
- R5: A write that moves the key from a value other than Ah to Ah raises `st_reset` from the next cycle. It stays high for 16, 32, 64 or 96 cycles, chosen by the divider code 0, 1, 2 or 3 held after that write.
- R6: Writing Ah again while the key already holds Ah does not restart or lengthen a reset pulse that is running.
- R7: A privileged write of any key other than Ah drops `st_enable` and `st_reset` in the next cycle, which cuts short any pulse in progress.
- R8: `rom_clk_en` is a one-cycle strobe with period 2^code cycles, where code is the divider code. Its phase counter restarts from zero when a write changes the code, so the first strobe comes 2^code cycles after that write.
- R9: Writes to any address other than `REG_ADDR` are ignored. Reads from such an address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Privilege qualifier for writes |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| st_enable | output | 1 | Self-test controller enable |
| st_reset | output | 1 | Reset pulse to the self-test state machine |
| rom_clk_en | output | 1 | Divided clock-enable strobe for the test ROM |

## Verification
Every result of this block is registered once, so each one is due in the cycle after the edge that accepts the stimulus. This holds for the enable level, the start or abort of the reset pulse, the restart of the strobe phase and the read data. The bench drives inputs at the falling edge. A behavioural model advances at each rising edge, and all four outputs are compared with the model 2 ns after that edge. Directed checks also count the width of each reset pulse over its full length, and they read back stored fields after ignored writes.

// File: rtl/stkey_pkg.sv
package stkey_pkg;

    localparam logic [3:0] KEY_ON    = 4'hA;
    localparam logic [3:0] KEY_RESET = 4'h5;

    typedef enum logic [1:0] {
        ROMDIV_1 = 2'd0,
        ROMDIV_2 = 2'd1,
        ROMDIV_4 = 2'd2,
        ROMDIV_8 = 2'd3
    } romdiv_e;

    typedef struct packed {
        logic [7:0] spare;
        romdiv_e    div;
        logic [3:0] key;
    } ctl_t;

    // Register image seen by a read; unused bits are zero.
    function automatic logic [31:0] pack_ctl(ctl_t c);
        return {8'h00, c.spare, 6'h00, 2'(c.div), 4'h0, c.key};
    endfunction

    // Unpack the writable fields from bus data.
    function automatic ctl_t unpack_ctl(logic [31:0] d);
        ctl_t c;
        c.spare = d[23:16];
        c.div   = romdiv_e'(d[9:8]);
        c.key   = d[3:0];
        return c;
    endfunction

    // Hold length in cycles: base x 1, 2, 4, 6 for codes 0..3.
    function automatic int unsigned hold_len(romdiv_e code, int unsigned base);
        return (code == ROMDIV_8) ? base * 6 : base << code;
    endfunction

endpackage

// File: rtl/stkey_regs.sv
module stkey_regs
    import stkey_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              priv,
    output ctl_t              ctl_q,
    output ctl_t              ctl_d,
    output logic              wr_hit,
    output logic [31:0]       rdata
);

    logic rd_hit;

    always_comb begin
        wr_hit = wr && priv && (addr == REG_ADDR);  // R3 R9
        rd_hit = rd && (addr == REG_ADDR);          // R9
        ctl_d  = ctl_q;
        if (wr_hit) begin
            ctl_d = unpack_ctl(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.spare <= 8'h00;                    // R1
            ctl_q.div   <= ROMDIV_1;
            ctl_q.key   <= KEY_RESET;
            rdata       <= 32'h0;
        end else begin
            ctl_q <= ctl_d;
            rdata <= rd_hit ? pack_ctl(ctl_q) : 32'h0;  // R4
        end
    end

    AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr && !priv) |=> $stable(ctl_q)); // R3

    AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr != REG_ADDR)) |=> $stable(ctl_q)); // R9

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata == 32'h0)); // R4

endmodule

// File: rtl/stkey_hold.sv
module stkey_hold
    import stkey_pkg::*;
#(
    parameter int unsigned BASE_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  logic [3:0] key_now,
    input  logic [3:0] key_next,
    input  romdiv_e    div_next,
    output logic       hold
);

    localparam int unsigned MAX_LEN = BASE_LEN * 6;
    localparam int unsigned CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt;
    logic          start;
    logic          abort;
    logic [CW-1:0] len;

    always_comb begin
        start = wr_hit && (key_next == KEY_ON) && (key_now != KEY_ON);  // R5 R6
        abort = wr_hit && (key_next != KEY_ON);                          // R7
        len   = CW'(hold_len(div_next, BASE_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign hold = (cnt != '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        start |=> hold); // R5

    AST_PULSE_ABORT: assert property (@(posedge clk) disable iff (rst)
        abort |=> !hold); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && (key_now == KEY_ON) && (key_next == KEY_ON) && (cnt > CW'(1)))
        |=> (cnt == $past(cnt) - CW'(1))); // R6

endmodule

// File: rtl/stkey_romdiv.sv
module stkey_romdiv
    import stkey_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_hit,
    input  romdiv_e div_now,
    input  romdiv_e div_next,
    output logic    strobe
);

    localparam int unsigned CNT_W = 3;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             clear;

    always_comb begin
        lim   = (CNT_W'(1) << div_now) - CNT_W'(1);
        clear = wr_hit && (div_next != div_now);  // R8
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt >= lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign strobe = (cnt == lim);

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        (strobe && (div_now != ROMDIV_1) && !clear) |=> !strobe); // R8

    AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (rst)
        (clear && (div_next != ROMDIV_1)) |=> !strobe); // R8

endmodule

// File: rtl/stkey_top.sv
module stkey_top
    import stkey_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
    parameter int unsigned       BASE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_priv,
    output logic [31:0]       bus_rdata,
    output logic              st_enable,
    output logic              st_reset,
    output logic              rom_clk_en
);

    ctl_t ctl_q;
    ctl_t ctl_d;
    logic wr_hit;

    stkey_regs #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .priv   (bus_priv),
        .ctl_q  (ctl_q),
        .ctl_d  (ctl_d),
        .wr_hit (wr_hit),
        .rdata  (bus_rdata)
    );

    stkey_hold #(
        .BASE_LEN (BASE_LEN)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .key_now  (ctl_q.key),
        .key_next (ctl_d.key),
        .div_next (ctl_d.div),
        .hold     (st_reset)
    );

    stkey_romdiv u_romdiv (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .div_now  (ctl_q.div),
        .div_next (ctl_d.div),
        .strobe   (rom_clk_en)
    );

    assign st_enable = (ctl_q.key == KEY_ON);  // R2

    AST_ENABLE_FOLLOWS_KEY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_priv && (bus_addr == REG_ADDR) && (bus_wdata[3:0] == KEY_ON))
        |=> st_enable); // R2

    AST_RESET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        st_reset |-> st_enable); // R7

endmodule

// File: tb/stkey_top_bench.sv
`timescale 1ns/1ps
module stkey_top_bench;

    localparam logic [7:0] REG = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_priv = 1'b0;
    logic [31:0] bus_rdata;
    logic        st_enable, st_reset, rom_clk_en;

    int checks = 0;
    int fails  = 0;
    int pc     = 0;
    bit done   = 0;

    // reference model state
    int          m_key = 5, m_div = 0, m_spare = 0, m_rcnt = 0, m_cnt = 0;
    logic [31:0] m_rdata = 0;

    always #4 clk = ~clk;

    stkey_top u_stkey_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .st_enable(st_enable), .st_reset(st_reset),
        .rom_clk_en(rom_clk_en)
    );

    function automatic int len_of(int d);
        return (d == 3) ? 96 : (16 << d);
    endfunction

    function automatic logic [31:0] img(int key, int dv, int sp);
        return (32'(sp & 255) << 16) | (32'(dv & 3) << 8) | 32'(key & 15);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_key = 5; m_div = 0; m_spare = 0; m_rcnt = 0; m_cnt = 0; m_rdata = 0;
        end else begin
            int nk, nd;
            bit hit;
            m_rdata = (bus_rd && bus_addr == REG) ? img(m_key, m_div, m_spare) : 32'h0;
            hit = bus_wr && bus_priv && bus_addr == REG;
            nk = hit ? int'(bus_wdata[3:0]) : m_key;
            nd = hit ? int'(bus_wdata[9:8]) : m_div;
            if (nd != m_div) m_cnt = 0;
            else m_cnt = (m_cnt + 1) % (1 << m_div);
            if (hit && nk != 10) m_rcnt = 0;
            else if (hit && m_key != 10) m_rcnt = len_of(nd);
            else if (m_rcnt > 0) m_rcnt = m_rcnt - 1;
            if (hit) m_spare = int'(bus_wdata[23:16]);
            m_key = nk; m_div = nd;
        end
    end

    // compare all outputs shortly after every rising edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R2/R7 st_enable", 32'(st_enable), 32'(m_key == 10));
            check("R5 st_reset", 32'(st_reset), 32'(m_rcnt != 0));
            check("R8 rom_clk_en", 32'(rom_clk_en), 32'(m_cnt == (1 << m_div) - 1));
            check("R4 bus_rdata", bus_rdata, m_rdata);
        end
    end

    always @(posedge clk) begin
        #3;
        if (st_reset) pc++;
    end

    task automatic wr(logic [7:0] a, logic [31:0] d, logic p);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_wr = 0; bus_priv = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 enable", 32'(st_enable), 0);
        check("R1 reset", 32'(st_reset), 0);
        rd(REG, v);
        check("R1 readback", v, 32'h0000_0005);
        // R4 reserved bits
        wr(REG, 32'hFFFF_FFFF, 1);
        rd(REG, v);
        check("R4 reserved zero", v, 32'h00FF_030F);
        check("R2 key F disabled", 32'(st_enable), 0);
        // R3 user write ignored
        wr(REG, 32'h0000_000A, 0);
        idle(2);
        check("R3 user write enable", 32'(st_enable), 0);
        rd(REG, v);
        check("R3 user write readback", v, 32'h00FF_030F);
        // R9 other address
        wr(8'h14, 32'h0000_000A, 1);
        idle(2);
        check("R9 other addr enable", 32'(st_enable), 0);
        rd(8'h14, v);
        check("R9 other addr read", v, 32'h0);
        // R5 pulse length per code, R6 no restart, R7 disable
        for (int d = 0; d < 4; d++) begin
            wr(REG, img(5, d, 0), 1);
            idle(20);
            pc = 0;
            wr(REG, img(10, d, 0), 1);
            check("R2 enable after key", 32'(st_enable), 1);
            idle(len_of(d) + 4);
            check("R5 pulse length", 32'(pc), 32'(len_of(d)));
            pc = 0;
            wr(REG, img(10, d, 0), 1);
            idle(8);
            check("R6 rewrite no pulse", 32'(pc), 0);
            wr(REG, img(3, d, 0), 1);
            check("R7 disable", 32'(st_enable), 0);
        end
        // R7 abort mid-pulse
        wr(REG, img(10, 3, 0), 1);
        idle(10);
        wr(REG, img(5, 3, 0), 1);
        check("R7 abort reset", 32'(st_reset), 0);
        check("R7 abort enable", 32'(st_enable), 0);
        // R6 rewrite during pulse keeps length
        pc = 0;
        wr(REG, img(10, 2, 0), 1);
        idle(5);
        wr(REG, img(10, 2, 0), 1);
        idle(80);
        check("R6 pulse not lengthened", 32'(pc), 64);
        // R8 divider changes with phase restart
        wr(REG, img(5, 1, 0), 1);
        idle(9);
        wr(REG, img(5, 3, 0), 1);
        idle(13);
        wr(REG, img(5, 0, 0), 1);
        idle(4);
        wr(REG, img(5, 2, 0), 1);
        idle(11);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule